// File: doc/BRIEF.md
# Shared-Pin Serial Configuration Loader

This block lets a host write a small bank of configuration registers through the pins of an 8-bit parallel output bus. While the line-sync input is low, the block drives the bus with the data presented on its parallel input. While line-sync is high, it releases the bus and reads three of its pads as serial pins: pad 7 is the load strobe (active low), pad 6 is serial data, and pad 5 is the serial clock.

A write is one 11-bit frame. The 3-bit register address comes first and the 8-bit value follows, each most significant bit first. The frame is committed when the load strobe rises, and only if exactly the first eleven clock rises were captured. The three serial pads are synchronised into the system clock, and their edges are detected there.

The register bank holds eight bytes: three gain registers, three offset registers and two mode registers. Two bits of the first mode register have special effects. One returns the whole bank to its power-up state. The other enters power-down, which keeps every stored value except two signal-configuration bits. All register contents are exported as a flat output vector.

Top module: `serial_cfg_loader`

## Requirements
- R1: While sync_i is high, bus_oe_o is 0. While sync_i is low, bus_oe_o is 1 and bus_pad_o equals bus_data_i.
- R2: A frame is 11 bits: address bits 2..0 followed by data bits 7..0, each most significant bit first. Each bit is taken from pad 6 on a rising edge of pad 5 while pad 7 is low. A falling edge of pad 7 starts a frame.
- R3: On the rising edge of pad 7 after exactly eleven captured bits, the addressed byte becomes the data value. Register k occupies cfg_o[8k+7:8k].
- R4: A frame that ends with fewer than eleven clock rises changes no register.
- R5: Clock rises after the eleventh in a frame are ignored. The first eleven bits are committed.
- R6: After reset, addresses 0, 2 and 4 (gains) hold 0x00, addresses 1, 3 and 5 (offsets) hold 0x40, and addresses 6 and 7 (mode) hold 0x00.
- R7: A write to address 6 with bit 6 set returns all eight registers to their R6 values.
- R8: A write to address 6 with bit 7 set and bit 6 clear stores the value with bits 5 and 0 forced to 0. All other registers keep their values.
- R9: Serial activity while sync_i is low does not write anything. If sync_i drops during a frame, that frame is abandoned.
- R10: Each falling edge of pad 7 clears the bit count and the shift state, so an earlier partial frame does not affect the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Line sync; high selects serial mode and releases the bus |
| bus_data_i | input | 8 | Parallel data to drive onto the bus |
| bus_pad_i | input | 8 | Pad input values (bit 7 load, bit 6 data, bit 5 clock) |
| bus_pad_o | output | 8 | Pad output values |
| bus_oe_o | output | 1 | Pad output enable |
| cfg_o | output | 64 | Flat register bank, register k at bits 8k+7:8k |

## Verification
The bench targets several frame-length corner cases:
- A ten-bit frame. A design that commits on any rising load edge would overwrite the register with shifted garbage.
- A fourteen-bit frame with trailing ones. A design that keeps shifting past eleven bits would commit the wrong address and data.
- A partial frame followed by a full one. A design that does not clear its state on the falling load edge would leave the second frame misaligned.

It also covers two mode-register cases. A reset-bit write must restore every default value, including registers written earlier. A power-down write must clear exactly bits 5 and 0 and leave the rest of the bank intact. Finally, it checks sync interaction: frames sent while sync is low, and a frame cut off by sync falling, must leave the bank unchanged.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  parameter int ADDR_W   = 3;
  parameter int DATA_W   = 8;
  parameter int NREG     = 2 ** ADDR_W;
  parameter int FRAME_W  = ADDR_W + DATA_W;
  parameter int CNT_W    = $clog2(FRAME_W + 1);
  parameter int PIN_LD   = 7;
  parameter int PIN_SDA  = 6;
  parameter int PIN_SCK  = 5;
  parameter logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(6);
  parameter int RST_BIT  = 6;
  parameter int PD_BIT   = 7;
  parameter logic [DATA_W-1:0] CFG_MASK   = DATA_W'(8'h21);
  parameter logic [DATA_W-1:0] OFFSET_DEF = DATA_W'(8'h40);
  parameter int NUM_CH   = 3;

  function automatic logic [DATA_W-1:0] reg_default(input int idx);
    if (idx < 2 * NUM_CH && idx[0]) return OFFSET_DEF;
    return '0;
  endfunction

  function automatic logic [NREG*DATA_W-1:0] bank_default();
    logic [NREG*DATA_W-1:0] v;
    for (int k = 0; k < NREG; k++) v[k*DATA_W +: DATA_W] = reg_default(k);
    return v;
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int         W      = 3,
  parameter int         STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import cfg_loader_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              ld_fall_i,
  input  logic              ld_rise_i,
  input  logic              sck_rise_i,
  input  logic              sda_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [FRAME_W-1:0] shift_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               act_q;
  logic               full;

  assign full = (cnt_q == CNT_W'(FRAME_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      cnt_q   <= '0;
      act_q   <= 1'b0;
    end else if (!sync_i) begin
      shift_q <= '0;
      cnt_q   <= '0;
      act_q   <= 1'b0;
    end else if (ld_fall_i) begin
      shift_q <= '0;
      cnt_q   <= '0;
      act_q   <= 1'b1;
    end else if (ld_rise_i) begin
      act_q   <= 1'b0;
    end else if (act_q && sck_rise_i && !full) begin
      shift_q <= {shift_q[FRAME_W-2:0], sda_i};
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign wr_en_o   = sync_i && act_q && ld_rise_i && full;
  assign wr_addr_o = shift_q[FRAME_W-1 -: ADDR_W];
  assign wr_data_o = shift_q[DATA_W-1:0];
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_loader_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  output logic [NREG*DATA_W-1:0] bank_o
);
  logic [DATA_W-1:0] regs_q [NREG];
  logic is_mode;

  assign is_mode = (wr_addr_i == MODE_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NREG; k++) regs_q[k] <= reg_default(k);
    end else if (wr_en_i) begin
      if (is_mode && wr_data_i[RST_BIT]) begin
        for (int k = 0; k < NREG; k++) regs_q[k] <= reg_default(k);
      end else if (is_mode && wr_data_i[PD_BIT]) begin
        regs_q[wr_addr_i] <= wr_data_i & ~CFG_MASK;
      end else begin
        regs_q[wr_addr_i] <= wr_data_i;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign bank_o[g*DATA_W +: DATA_W] = regs_q[g];
  end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sync_i,
  input  logic [DATA_W-1:0]      bus_data_i,
  input  logic [DATA_W-1:0]      bus_pad_i,
  output logic [DATA_W-1:0]      bus_pad_o,
  output logic                   bus_oe_o,
  output logic [NREG*DATA_W-1:0] cfg_o
);
  localparam logic [2:0] PIN_IDLE = 3'b100;  // load strobe idles high

  logic [2:0] pins_s, pins_p;
  logic ld_fall, ld_rise, sck_rise;
  logic wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [CNT_W-1:0]  bit_cnt;

  // serial mode releases the bus
  assign bus_oe_o  = !sync_i;
  assign bus_pad_o = bus_data_i;

  pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({bus_pad_i[PIN_LD], bus_pad_i[PIN_SDA], bus_pad_i[PIN_SCK]}),
    .sync_o (pins_s),
    .prev_o (pins_p)
  );

  assign ld_fall  = !pins_s[2] &&  pins_p[2];
  assign ld_rise  =  pins_s[2] && !pins_p[2];
  assign sck_rise =  pins_s[0] && !pins_p[0];

  frame_shifter u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_i),
    .ld_fall_i  (ld_fall),
    .ld_rise_i  (ld_rise),
    .sck_rise_i (sck_rise),
    .sda_i      (pins_s[1]),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .cnt_o      (bit_cnt)
  );

  cfg_regfile u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .bank_o    (cfg_o)
  );
endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk
  import cfg_loader_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   sync_i,
  input logic                   wr_en,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic [DATA_W-1:0]      wr_data,
  input logic [CNT_W-1:0]       bit_cnt,
  input logic                   ld_fall,
  input logic [NREG*DATA_W-1:0] cfg
);
  localparam int MODE_LSB = int'(MODE_ADDR) * DATA_W;

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= CNT_W'(FRAME_W));

  p_hold_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(cfg));

  p_soft_reset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr == MODE_ADDR && wr_data[RST_BIT]) |=> (cfg == bank_default()));

  p_pwrdn_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr == MODE_ADDR && wr_data[PD_BIT] && !wr_data[RST_BIT])
      |=> ((cfg[MODE_LSB +: DATA_W] & CFG_MASK) == '0) && cfg[MODE_LSB + PD_BIT]);

  p_unsynced_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> bit_cnt == '0);

  p_frame_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_fall && sync_i) |=> bit_cnt == '0);
endmodule

bind serial_cfg_loader serial_cfg_loader_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sync_i  (sync_i),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .bit_cnt (bit_cnt),
  .ld_fall (ld_fall),
  .cfg     (cfg_o)
);

// File: tb/serial_cfg_loader_tb.sv
module serial_cfg_loader_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic ld = 1'b1, sck = 1'b0, sda = 1'b0;
  logic [7:0] pad_o;
  logic oe;
  logic [63:0] cfg;
  logic pending = 1'b1;
  logic done = 1'b0;
  int checks = 0, fails = 0;
  logic [7:0] model [8];

  always #5 clk = ~clk;

  serial_cfg_loader u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .bus_data_i(data_in),
    .bus_pad_i({ld, sda, sck, 5'b00000}), .bus_pad_o(pad_o), .bus_oe_o(oe), .cfg_o(cfg)
  );

  always @(negedge clk) data_in <= data_in + 8'd37;

  function automatic logic [7:0] dflt(input int k);
    return (k < 6 && (k % 2) == 1) ? 8'h40 : 8'h00;
  endfunction

  function automatic logic [7:0] rd(input int k);
    return cfg[k*8 +: 8];
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 8; k++) model[k] = dflt(k);
  endtask

  task automatic model_write(input logic [2:0] a, input logic [7:0] d);
    if (a == 3'd6 && d[6]) model_reset();
    else if (a == 3'd6 && d[7]) model[a] = d & 8'hDE;
    else model[a] = d;
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the behavioural model
  always @(posedge clk) begin
    #2;
    if (rst_n && !pending) begin
      logic [63:0] exp;
      for (int k = 0; k < 8; k++) exp[k*8 +: 8] = model[k];
      check(cfg == exp, "R3 bank vs model", cfg, exp);
      check(oe == !sync && (sync || pad_o == data_in), "R1 bus ownership",
            {55'd0, oe, pad_o}, {55'd0, !sync, data_in});
    end
  end

  task automatic step();
    pending = 1'b1;
    repeat (6) @(negedge clk);
    pending = 1'b0;
    @(negedge clk);
  endtask

  task automatic clock_bit(input logic b);
    sda = b; sck = 1'b0; step();
    sck = 1'b1; step();
  endtask

  task automatic send(input logic [2:0] a, input logic [7:0] d, input int n);
    logic [10:0] f;
    f = {a, d};
    ld = 1'b0; sck = 1'b0; step();
    for (int i = 0; i < n; i++) clock_bit(i < 11 ? f[10-i] : 1'b1);
    sck = 1'b0; step();
    if (n >= 11 && sync) model_write(a, d);
    ld = 1'b1; step();
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    pending = 1'b0;
    @(negedge clk);
    // R6 power-up
    for (int k = 0; k < 8; k++) check(rd(k) == dflt(k), "R6 reset value", rd(k), dflt(k));
    check(oe == 1'b1, "R1 bus driven with sync low", oe, 1);
    sync = 1'b1; step();
    check(oe == 1'b0, "R1 bus released with sync high", oe, 0);
    // R2 / R3 bit order and addressing
    send(3'd3, 8'hA5, 11);
    check(rd(3) == 8'hA5, "R2 msb-first frame", rd(3), 8'hA5);
    send(3'd0, 8'h3C, 11);
    check(rd(0) == 8'h3C, "R3 addressed write", rd(0), 8'h3C);
    send(3'd7, 8'h81, 11);
    check(rd(7) == 8'h81, "R3 mode-test write", rd(7), 8'h81);
    // R4 short frame
    send(3'd4, 8'hFF, 10);
    check(rd(4) == 8'h00, "R4 short frame ignored", rd(4), 8'h00);
    // R5 long frame
    send(3'd5, 8'h12, 14);
    check(rd(5) == 8'h12, "R5 extra clocks ignored", rd(5), 8'h12);
    check(rd(7) == 8'h81, "R5 no spill to other reg", rd(7), 8'h81);
    // R10 partial frame then full
    send(3'd2, 8'hFF, 5);
    send(3'd2, 8'h5A, 11);
    check(rd(2) == 8'h5A, "R10 fresh frame state", rd(2), 8'h5A);
    // R8 power-down
    send(3'd6, 8'hA1, 11);
    check(rd(6) == 8'h80, "R8 config bits cleared", rd(6), 8'h80);
    check(rd(3) == 8'hA5, "R8 others retained", rd(3), 8'hA5);
    send(3'd6, 8'h21, 11);
    check(rd(6) == 8'h21, "R8 reprogram after exit", rd(6), 8'h21);
    // R9 sync low frame
    sync = 1'b0; step();
    send(3'd1, 8'h99, 11);
    check(rd(1) == 8'h40, "R9 frame with sync low", rd(1), 8'h40);
    // R9 aborted frame
    sync = 1'b1; step();
    ld = 1'b0; step();
    for (int i = 0; i < 6; i++) clock_bit(1'b0);
    sync = 1'b0; step();
    for (int i = 0; i < 5; i++) clock_bit(1'b1);
    ld = 1'b1; step();
    sync = 1'b1; step();
    check(rd(0) == 8'h3C, "R9 aborted frame", rd(0), 8'h3C);
    // R7 soft reset
    send(3'd6, 8'h40, 11);
    for (int k = 0; k < 8; k++) check(rd(k) == dflt(k), "R7 soft reset", rd(k), dflt(k));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule